// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block keeps the instructions of a speculative out-of-order integer core in program order from the moment they issue until they retire. Each issued instruction takes one slot at the tail of a circular buffer. The slot number goes back to the issue stage as the tag that the instruction's result will carry. Execution units later broadcast results on a shared result bus. Each broadcast names a slot by its tag, and the value lands in that slot, which is then marked complete.

Retirement happens only at the head, and only once the head slot is complete. The action taken depends on what the instruction is:

- An arithmetic or load instruction writes its destination register.
- A store writes data memory.
- A branch whose predicted direction matches its resolved direction leaves quietly.
- A branch whose prediction was wrong discards every younger slot, clears all pending register mappings, and sends fetch to the correct successor address.

A register-mapping table records, for each architectural register, the youngest in-flight slot that will write it. With this table and the slot contents, issue can learn whether a source operand is still pending, which tag to wait for, and whether the value is already waiting in the buffer. The asynchronous active-low reset is released through a two-stage synchronizer inside the block.

Top module: `rob_core`

## Requirements
- R1: `iss_ready` is low while DEPTH slots are occupied and during a cycle in which a flush takes place. An `iss_valid` presented while `iss_ready` is low allocates nothing and leaves the register mapping unchanged.
- R2: `iss_tag` gives the slot that the next accepted instruction receives. Tags are handed out consecutively modulo DEPTH, starting at 0 after reset and again after every flush.
- R3: A result-bus write (`cdb_valid`) to an occupied slot stores `cdb_value`, `cdb_addr` and `cdb_taken` and marks the slot complete. A source lookup that maps to that slot then reports ready, with the stored value.
- R4: Only the head slot retires, and only once it is complete. Results that arrive out of order are held back, so slots retire in allocation order, one per cycle. At most one of `rf_we`, `mem_we` and `redirect_valid` is high in a cycle.
- R5: When an arithmetic slot (`iss_kind` 0 or 3) retires, `rf_we` is high with `rf_waddr` equal to its destination and `rf_wdata` equal to its result.
- R6: An arithmetic slot whose destination is register 0 retires without raising `rf_we`.
- R7: A store slot (`iss_kind` 1) retires with `mem_we` high, `mem_addr` = `cdb_addr` and `mem_wdata` = `cdb_value`, and without `rf_we`.
- R8: A branch slot (`iss_kind` 2) whose `cdb_taken` differs from `iss_pred_taken` raises `redirect_valid` with `redirect_pc` = `cdb_addr` in its retire cycle. In the next cycle the buffer is empty, no register is mapped, and younger slots never retire.
- R9: A branch slot whose `cdb_taken` equals its prediction retires with none of `rf_we`, `mem_we` or `redirect_valid` raised.
- R10: A source lookup on a register reports busy with the tag of the youngest pending arithmetic slot that writes it. A retirement clears the mapping only when the mapping still names the retiring slot. Register 0 is never busy.
- R11: After reset the buffer is empty, `iss_ready` is high, `iss_tag` is 0, and all retire outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue stage presents an instruction |
| iss_kind | input | 2 | 0/3 arithmetic, 1 store, 2 branch |
| iss_rd | input | RW | Destination register |
| iss_pred_taken | input | 1 | Predicted branch direction |
| iss_ready | output | 1 | A slot can be allocated this cycle |
| iss_tag | output | TW | Slot given to the next accepted instruction |
| src1_reg | input | RW | First source register to look up |
| src1_busy | output | 1 | First source has a pending producer |
| src1_ready | output | 1 | That producer's result is in the buffer |
| src1_tag | output | TW | Slot of that producer |
| src1_value | output | XLEN | Buffered value of that producer |
| src2_reg | input | RW | Second source register to look up |
| src2_busy | output | 1 | Second source has a pending producer |
| src2_ready | output | 1 | That producer's result is in the buffer |
| src2_tag | output | TW | Slot of that producer |
| src2_value | output | XLEN | Buffered value of that producer |
| cdb_valid | input | 1 | Result bus carries a result |
| cdb_tag | input | TW | Slot the result belongs to |
| cdb_value | input | XLEN | Result, or store data |
| cdb_addr | input | XLEN | Store address, or branch correct successor |
| cdb_taken | input | 1 | Resolved branch direction |
| rob_empty | output | 1 | No slot occupied |
| rf_we | output | 1 | Register-file write this cycle |
| rf_waddr | output | RW | Register written |
| rf_wdata | output | XLEN | Data written |
| mem_we | output | 1 | Data-memory write this cycle |
| mem_addr | output | XLEN | Memory address |
| mem_wdata | output | XLEN | Memory data |
| redirect_valid | output | 1 | Flush and fetch restart this cycle |
| redirect_pc | output | XLEN | Address to restart fetch from |

## Verification
The bench uses a four-slot buffer and fills it completely over several rounds, so that the tags wrap around and the destinations include register 0. In each round it returns results in reverse order. This separates true in-order retirement from "retire whatever completed", and shows that completions out of order are held until the head is ready. Two back-to-back writers of one register show whether retirement clears a mapping it no longer owns. Stores, correctly predicted branches and branches mispredicted in both directions (with completed younger arithmetic and store slots behind them) distinguish the three retire paths. They also show that a flush discards completed younger work rather than retiring it.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    K_ALU    = 2'd0,
    K_STORE  = 2'd1,
    K_BRANCH = 2'd2
  } rob_kind_e;

  function automatic rob_kind_e decode_kind(input logic [1:0] code);
    case (code)
      2'd1:    return K_STORE;
      2'd2:    return K_BRANCH;
      default: return K_ALU;
    endcase
  endfunction
endpackage

// File: rtl/rob_rst_sync.sv
module rob_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_n_sync = stage2_q;
endmodule

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc,
  input  logic          retire,
  input  logic          flush,
  output logic [TW-1:0] head,
  output logic [TW-1:0] tail,
  output logic          full,
  output logic          empty
);
  localparam int CW = TW + 1;
  localparam logic [TW-1:0] LAST = TW'(DEPTH - 1);

  logic [TW-1:0] head_q, head_d, tail_q, tail_d;
  logic [CW-1:0] count_q, count_d;
  logic          ptr_en;

  function automatic logic [TW-1:0] wrap_inc(input logic [TW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    head_d  = head_q;
    tail_d  = tail_q;
    count_d = count_q;
    if (flush) begin
      head_d  = '0;
      tail_d  = '0;
      count_d = '0;
    end else begin
      if (retire) head_d = wrap_inc(head_q);
      if (alloc)  tail_d = wrap_inc(tail_q);
      case ({alloc, retire})
        2'b10:   count_d = count_q + 1'b1;
        2'b01:   count_d = count_q - 1'b1;
        default: count_d = count_q;
      endcase
    end
  end

  assign ptr_en = flush | alloc | retire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else if (ptr_en) begin
      head_q  <= head_d;
      tail_q  <= tail_d;
      count_q <= count_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign full  = (count_q == CW'(DEPTH));
  assign empty = (count_q == '0);
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int RW    = 5,
  parameter int TW    = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            alloc,
  input  logic [TW-1:0]   tail,
  input  rob_kind_e       alloc_kind,
  input  logic [RW-1:0]   alloc_rd,
  input  logic            alloc_pred,
  input  logic            retire,
  input  logic [TW-1:0]   head,
  input  logic            cdb_valid,
  input  logic [TW-1:0]   cdb_tag,
  input  logic [XLEN-1:0] cdb_value,
  input  logic [XLEN-1:0] cdb_addr,
  input  logic            cdb_taken,
  output logic            head_valid,
  output logic            head_done,
  output rob_kind_e       head_kind,
  output logic [RW-1:0]   head_rd,
  output logic [XLEN-1:0] head_value,
  output logic [XLEN-1:0] head_addr,
  output logic            head_mispred,
  input  logic [TW-1:0]   look1_tag,
  output logic            look1_done,
  output logic [XLEN-1:0] look1_value,
  input  logic [TW-1:0]   look2_tag,
  output logic            look2_done,
  output logic [XLEN-1:0] look2_value
);
  typedef struct packed {
    logic            valid;
    logic            done;
    rob_kind_e       kind;
    logic [RW-1:0]   rd;
    logic [XLEN-1:0] value;
    logic [XLEN-1:0] addr;
    logic            pred;
    logic            taken;
  } slot_t;

  slot_t slot_q [DEPTH];
  slot_t slot_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic hit_alloc, hit_retire, hit_cdb, slot_en;

    assign hit_alloc  = alloc  && (tail == TW'(g));
    assign hit_retire = retire && (head == TW'(g));
    assign hit_cdb    = cdb_valid && (cdb_tag == TW'(g)) && slot_q[g].valid;
    assign slot_en    = flush | hit_alloc | hit_retire | hit_cdb;

    always_comb begin
      slot_d[g] = slot_q[g];
      if (flush) begin
        slot_d[g].valid = 1'b0;
        slot_d[g].done  = 1'b0;
      end else begin
        if (hit_retire) begin
          slot_d[g].valid = 1'b0;
          slot_d[g].done  = 1'b0;
        end
        if (hit_cdb) begin
          slot_d[g].done  = 1'b1;
          slot_d[g].value = cdb_value;
          slot_d[g].addr  = cdb_addr;
          slot_d[g].taken = cdb_taken;
        end
        if (hit_alloc) begin
          slot_d[g].valid = 1'b1;
          slot_d[g].done  = 1'b0;
          slot_d[g].kind  = alloc_kind;
          slot_d[g].rd    = alloc_rd;
          slot_d[g].pred  = alloc_pred;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_q[g] <= '0;
      end else if (slot_en) begin
        slot_q[g] <= slot_d[g];
      end
    end
  end

  assign head_valid   = slot_q[head].valid;
  assign head_done    = slot_q[head].done;
  assign head_kind    = slot_q[head].kind;
  assign head_rd      = slot_q[head].rd;
  assign head_value   = slot_q[head].value;
  assign head_addr    = slot_q[head].addr;
  assign head_mispred = slot_q[head].pred ^ slot_q[head].taken;

  assign look1_done  = slot_q[look1_tag].valid & slot_q[look1_tag].done;
  assign look1_value = slot_q[look1_tag].value;
  assign look2_done  = slot_q[look2_tag].valid & slot_q[look2_tag].done;
  assign look2_value = slot_q[look2_tag].value;
endmodule

// File: rtl/rob_regstat.sv
module rob_regstat #(
  parameter int NREG = 32,
  parameter int RW   = $clog2(NREG),
  parameter int TW   = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          set_en,
  input  logic [RW-1:0] set_reg,
  input  logic [TW-1:0] set_tag,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_reg,
  input  logic [TW-1:0] clr_tag,
  input  logic [RW-1:0] q1_reg,
  output logic          q1_busy,
  output logic [TW-1:0] q1_tag,
  input  logic [RW-1:0] q2_reg,
  output logic          q2_busy,
  output logic [TW-1:0] q2_tag
);
  logic [NREG-1:0] busy_q;
  logic [TW-1:0]   tag_q [NREG];

  assign busy_q[0] = 1'b0;
  assign tag_q[0]  = '0;

  for (genvar r = 1; r < NREG; r++) begin : g_reg
    logic          hit_set, hit_clr, busy_d, map_en;
    logic [TW-1:0] tag_d;

    assign hit_set = set_en && (set_reg == RW'(r));
    assign hit_clr = clr_en && (clr_reg == RW'(r)) && busy_q[r] && (tag_q[r] == clr_tag);
    assign map_en  = flush | hit_set | hit_clr;

    always_comb begin
      busy_d = busy_q[r];
      tag_d  = tag_q[r];
      if (flush) begin
        busy_d = 1'b0;
      end else if (hit_set) begin
        busy_d = 1'b1;
        tag_d  = set_tag;
      end else if (hit_clr) begin
        busy_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q[r] <= 1'b0;
        tag_q[r]  <= '0;
      end else if (map_en) begin
        busy_q[r] <= busy_d;
        tag_q[r]  <= tag_d;
      end
    end
  end

  assign q1_busy = busy_q[q1_reg];
  assign q1_tag  = tag_q[q1_reg];
  assign q2_busy = busy_q[q2_reg];
  assign q2_tag  = tag_q[q2_reg];
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  localparam int TW   = $clog2(DEPTH),
  localparam int RW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            iss_valid,
  input  logic [1:0]      iss_kind,
  input  logic [RW-1:0]   iss_rd,
  input  logic            iss_pred_taken,
  output logic            iss_ready,
  output logic [TW-1:0]   iss_tag,
  input  logic [RW-1:0]   src1_reg,
  output logic            src1_busy,
  output logic            src1_ready,
  output logic [TW-1:0]   src1_tag,
  output logic [XLEN-1:0] src1_value,
  input  logic [RW-1:0]   src2_reg,
  output logic            src2_busy,
  output logic            src2_ready,
  output logic [TW-1:0]   src2_tag,
  output logic [XLEN-1:0] src2_value,
  input  logic            cdb_valid,
  input  logic [TW-1:0]   cdb_tag,
  input  logic [XLEN-1:0] cdb_value,
  input  logic [XLEN-1:0] cdb_addr,
  input  logic            cdb_taken,
  output logic            rob_empty,
  output logic            rf_we,
  output logic [RW-1:0]   rf_waddr,
  output logic [XLEN-1:0] rf_wdata,
  output logic            mem_we,
  output logic [XLEN-1:0] mem_addr,
  output logic [XLEN-1:0] mem_wdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc
);
  logic            rst_n_int;
  logic [TW-1:0]   head, tail;
  logic            full, empty;
  logic            alloc, commit_go, flush;
  rob_kind_e       in_kind, head_kind;
  logic            head_valid, head_done, head_mispred;
  logic [RW-1:0]   head_rd;
  logic [XLEN-1:0] head_value, head_addr;
  logic            is_alu, is_store, is_branch;
  logic            map_set;
  logic            l1_done, l2_done;
  logic [XLEN-1:0] l1_value, l2_value;

  rob_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign in_kind   = decode_kind(iss_kind);
  assign iss_ready = !full && !flush;
  assign alloc     = iss_valid && iss_ready;
  assign iss_tag   = tail;

  assign is_alu    = (head_kind == K_ALU);
  assign is_store  = (head_kind == K_STORE);
  assign is_branch = (head_kind == K_BRANCH);
  assign commit_go = head_valid && head_done;
  assign flush     = commit_go && is_branch && head_mispred;

  rob_ptrs #(.DEPTH(DEPTH), .TW(TW)) u_ptrs (
    .clk    (clk),
    .rst_n  (rst_n_int),
    .alloc  (alloc),
    .retire (commit_go),
    .flush  (flush),
    .head   (head),
    .tail   (tail),
    .full   (full),
    .empty  (empty)
  );

  rob_entries #(.DEPTH(DEPTH), .XLEN(XLEN), .RW(RW), .TW(TW)) u_slots (
    .clk          (clk),
    .rst_n        (rst_n_int),
    .flush        (flush),
    .alloc        (alloc),
    .tail         (tail),
    .alloc_kind   (in_kind),
    .alloc_rd     (iss_rd),
    .alloc_pred   (iss_pred_taken),
    .retire       (commit_go),
    .head         (head),
    .cdb_valid    (cdb_valid),
    .cdb_tag      (cdb_tag),
    .cdb_value    (cdb_value),
    .cdb_addr     (cdb_addr),
    .cdb_taken    (cdb_taken),
    .head_valid   (head_valid),
    .head_done    (head_done),
    .head_kind    (head_kind),
    .head_rd      (head_rd),
    .head_value   (head_value),
    .head_addr    (head_addr),
    .head_mispred (head_mispred),
    .look1_tag    (src1_tag),
    .look1_done   (l1_done),
    .look1_value  (l1_value),
    .look2_tag    (src2_tag),
    .look2_done   (l2_done),
    .look2_value  (l2_value)
  );

  assign map_set = alloc && (in_kind == K_ALU) && (iss_rd != '0);

  rob_regstat #(.NREG(NREG), .RW(RW), .TW(TW)) u_map (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .flush   (flush),
    .set_en  (map_set),
    .set_reg (iss_rd),
    .set_tag (tail),
    .clr_en  (commit_go && is_alu),
    .clr_reg (head_rd),
    .clr_tag (head),
    .q1_reg  (src1_reg),
    .q1_busy (src1_busy),
    .q1_tag  (src1_tag),
    .q2_reg  (src2_reg),
    .q2_busy (src2_busy),
    .q2_tag  (src2_tag)
  );

  assign src1_ready = src1_busy && l1_done;
  assign src1_value = l1_value;
  assign src2_ready = src2_busy && l2_done;
  assign src2_value = l2_value;

  assign rob_empty      = empty;
  assign rf_we          = commit_go && is_alu && (head_rd != '0);
  assign rf_waddr       = head_rd;
  assign rf_wdata       = head_value;
  assign mem_we         = commit_go && is_store;
  assign mem_addr       = head_addr;
  assign mem_wdata      = head_value;
  assign redirect_valid = flush;
  assign redirect_pc    = head_addr;
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  parameter int RW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          iss_valid,
  input logic          iss_ready,
  input logic          retire,
  input logic          rob_empty,
  input logic          rf_we,
  input logic [RW-1:0] rf_waddr,
  input logic          mem_we,
  input logic          redirect_valid
);
  int unsigned occ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= 0;
    end else if (redirect_valid) begin
      occ <= 0;
    end else begin
      occ <= occ + ((iss_valid && iss_ready) ? 1 : 0) - (retire ? 1 : 0);
    end
  end

  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= DEPTH);
  assert_no_issue_on_flush_R1: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> !iss_ready);
  assert_empty_tracks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty == (occ == 0));
  assert_retire_nonempty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    retire |-> !rob_empty);
  assert_one_action_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_we, mem_we, redirect_valid}));
  assert_no_x0_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != '0));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |=> rob_empty);
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .RW(RW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .iss_valid      (iss_valid),
  .iss_ready      (iss_ready),
  .retire         (commit_go),
  .rob_empty      (rob_empty),
  .rf_we          (rf_we),
  .rf_waddr       (rf_waddr),
  .mem_we         (mem_we),
  .redirect_valid (redirect_valid)
);

// File: tb/rob_core_tb.sv
`timescale 1ns/1ps
module rob_core_tb;
  localparam int D = 4;

  logic        clk, rst_n;
  logic        iss_valid, iss_pred_taken, iss_ready;
  logic [1:0]  iss_kind;
  logic [4:0]  iss_rd, src1_reg, src2_reg, rf_waddr;
  logic [1:0]  iss_tag, src1_tag, src2_tag, cdb_tag;
  logic        src1_busy, src1_ready, src2_busy, src2_ready;
  logic [31:0] src1_value, src2_value, cdb_value, cdb_addr;
  logic        cdb_valid, cdb_taken, rob_empty, rf_we, mem_we, redirect_valid;
  logic [31:0] rf_wdata, mem_addr, mem_wdata, redirect_pc;

  int tests = 0, fails = 0, exp_tag = 0, last_tag = 0;

  rob_core #(.DEPTH(D), .XLEN(32), .NREG(32)) u_dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk); #1;
  endtask

  task automatic do_issue(input logic [1:0] k, input int rd, input logic pred, input string req);
    @(negedge clk);
    iss_valid = 1'b1; iss_kind = k; iss_rd = rd[4:0]; iss_pred_taken = pred;
    #1;
    chk({req, " ready"}, {31'b0, iss_ready}, 1);
    chk({req, " tag"}, {30'b0, iss_tag}, exp_tag);
    last_tag = exp_tag;
    @(posedge clk); #1;
    iss_valid = 1'b0;
    exp_tag = (exp_tag + 1) % D;
  endtask

  task automatic do_cdb(input int tag, input logic [31:0] val, input logic [31:0] addr, input logic tk);
    @(negedge clk);
    cdb_valid = 1'b1; cdb_tag = tag[1:0]; cdb_value = val; cdb_addr = addr; cdb_taken = tk;
    @(posedge clk); #1;
    cdb_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int tg [D];
    int rds [D];
    logic [31:0] vals [D];
    rst_n = 1'b0; iss_valid = 0; iss_kind = 0; iss_rd = 0; iss_pred_taken = 0;
    src1_reg = 0; src2_reg = 0; cdb_valid = 0; cdb_tag = 0; cdb_value = 0;
    cdb_addr = 0; cdb_taken = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    idle();
    // R11 reset state
    chk("R11 empty", {31'b0, rob_empty}, 1);
    chk("R11 ready", {31'b0, iss_ready}, 1);
    chk("R11 tag", {30'b0, iss_tag}, 0);
    chk("R11 outputs", {29'b0, rf_we, mem_we, redirect_valid}, 0);

    // Sweep: fill, reverse completion, in-order drain (R1 R2 R4 R5 R6)
    for (int r = 0; r < 5; r++) begin
      for (int i = 0; i < D; i++) begin
        rds[i] = (r * 5 + i) % 32;
        vals[i] = 32'h1000 * r + i * 17 + 1;
        do_issue(2'd0, rds[i], 1'b0, "R2 sweep issue");
        tg[i] = last_tag;
      end
      // R1 blocked issue while full, rd 31
      @(negedge clk);
      iss_valid = 1'b1; iss_kind = 2'd0; iss_rd = 5'd31; src1_reg = 5'd31;
      #1;
      chk("R1 full not ready", {31'b0, iss_ready}, 0);
      @(posedge clk); #1; iss_valid = 1'b0;
      idle();
      chk("R1 blocked no mapping", {31'b0, src1_busy}, 0);
      for (int i = D - 1; i > 0; i--) begin
        do_cdb(tg[i], vals[i], 0, 0);
        idle();
        chk("R4 no early retire", {30'b0, rf_we, mem_we}, 0);
      end
      do_cdb(tg[0], vals[0], 0, 0);
      for (int i = 0; i < D; i++) begin
        idle();
        if (rds[i] == 0) begin
          chk("R6 x0 no write", {31'b0, rf_we}, 0);
        end else begin
          chk("R5 we", {31'b0, rf_we}, 1);
          chk("R5 waddr", {27'b0, rf_waddr}, rds[i]);
          chk("R5 wdata", rf_wdata, vals[i]);
        end
      end
      idle();
      chk("R4 drained", {31'b0, rob_empty}, 1);
    end

    // R10 / R3 mapping and bypass
    src1_reg = 5'd5; src2_reg = 5'd0;
    do_issue(2'd0, 5, 1'b0, "R10 issue a"); tg[0] = last_tag;
    do_issue(2'd3, 5, 1'b0, "R10 issue b"); tg[1] = last_tag;
    idle();
    chk("R10 busy", {31'b0, src1_busy}, 1);
    chk("R10 youngest tag", {30'b0, src1_tag}, tg[1]);
    chk("R10 x0 never busy", {31'b0, src2_busy}, 0);
    do_cdb(tg[0], 32'hAAAA, 0, 0);
    idle();
    chk("R5 first writer", rf_wdata, 32'hAAAA);
    idle();
    chk("R10 not cleared by older", {31'b0, src1_busy}, 1);
    chk("R10 still tag b", {30'b0, src1_tag}, tg[1]);
    chk("R3 not ready yet", {31'b0, src1_ready}, 0);
    do_cdb(tg[1], 32'hBBBB, 0, 0);
    #1;
    chk("R3 ready", {31'b0, src1_ready}, 1);
    chk("R3 value", src1_value, 32'hBBBB);
    idle();
    chk("R5 second writer", rf_wdata, 32'hBBBB);
    idle();
    chk("R10 cleared", {31'b0, src1_busy}, 0);

    // R7 store
    do_issue(2'd1, 9, 1'b0, "R7 issue"); tg[0] = last_tag;
    do_cdb(tg[0], 32'hDEAD0001, 32'h0000_0840, 0);
    idle();
    chk("R7 mem_we", {31'b0, mem_we}, 1);
    chk("R7 addr", mem_addr, 32'h840);
    chk("R7 data", mem_wdata, 32'hDEAD0001);
    chk("R7 no rf_we", {31'b0, rf_we}, 0);

    // R9 correct branches
    for (int p = 0; p < 2; p++) begin
      do_issue(2'd2, 0, p[0], "R9 issue"); tg[0] = last_tag;
      do_cdb(tg[0], 0, 32'h2000, p[0]);
      idle();
      chk("R9 silent retire", {29'b0, rf_we, mem_we, redirect_valid}, 0);
      idle();
      chk("R9 retired", {31'b0, rob_empty}, 1);
    end

    // R8 mispredict both directions, completed younger work discarded
    for (int p = 0; p < 2; p++) begin
      src1_reg = 5'd7;
      do_issue(2'd2, 0, p[0], "R8 issue br"); tg[0] = last_tag;
      do_issue(2'd0, 7, 1'b0, "R8 issue alu"); tg[1] = last_tag;
      do_issue(2'd1, 0, 1'b0, "R8 issue st"); tg[2] = last_tag;
      do_cdb(tg[1], 32'h77, 0, 0);
      do_cdb(tg[2], 32'h55, 32'h300, 0);
      do_cdb(tg[0], 0, 32'h400 + p * 4, ~p[0]);
      idle();
      chk("R8 redirect", {31'b0, redirect_valid}, 1);
      chk("R8 pc", redirect_pc, 32'h400 + p * 4);
      chk("R1 no issue on flush", {31'b0, iss_ready}, 0);
      idle();
      exp_tag = 0;
      chk("R8 empty", {31'b0, rob_empty}, 1);
      chk("R8 tag restart", {30'b0, iss_tag}, 0);
      chk("R8 map cleared", {31'b0, src1_busy}, 0);
      chk("R8 younger not retired", {30'b0, rf_we, mem_we}, 0);
      idle();
      chk("R8 still quiet", {29'b0, rf_we, mem_we, redirect_valid}, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule